// File: doc/BRIEF.md
# Independent Prescaled Watchdog Counter

This block is a down-counting watchdog. It runs from its own slow clock, which is separate from the bus clock that software uses to program it. A small write-only register port in the bus domain takes three kinds of access. Key words start the watchdog, refresh it, or open the configuration for one change. The configuration words set a 3-bit divide code and a 12-bit reload value. Every accepted command is handed to the slow domain through a toggle handshake. The `busy` output stays high until the slow side has applied the command.

Once started, the watchdog cannot be stopped by any write; only the reset inputs return it to the off state. The slow side divides its clock by the selected ratio and takes one count off the reload value per divided tick. When the count is used up, it drives `reset_req` high for exactly two slow cycles, reloads, and starts over. The timeout in seconds is the ratio times the reload divided by the slow-clock frequency, so a 32 kHz clock with ratio 64 and reload 500 gives one second. A debug-halt input freezes the count. The count keeps advancing when the bus clock has stopped.

The bus side has a two-state machine. BUS_IDLE goes to BUS_WAIT when any command is pending; this launches the command and flips the request toggle. BUS_WAIT returns to BUS_IDLE when the synchronised acknowledge equals the request toggle. The slow side has four states:

- ST_OFF goes to ST_RUN on a start command.
- ST_RUN goes to ST_HALT when the synchronised halt is high.
- ST_HALT goes back to ST_RUN when the halt drops.
- ST_RUN goes to ST_FIRE on the divided tick that uses up the count.
- ST_FIRE goes to ST_RUN after two cycles, with a reload.
- A refresh keeps ST_RUN or ST_HALT in place and reloads the count.

Top module: `iwdg_top`

## Requirements
- R1: After reset, `reset_req`, `busy` and `armed` are 0, and no pulse appears on `reset_req`.
- R2: A write of 0xCCCC to address 0 starts the counter, and `armed` reads 1 from the next bus cycle. Other values at address 0 that are not keys (0xAAAA refresh, 0x5555 unlock) have no effect, and before a start there is no pulse.
- R3: No write clears `armed` or stops the pulses once started; only reset does.
- R4: Address 1 (bits 2:0, divide code) and address 2 (bits 11:0, reload) are written only after a 0x5555 unlock. A later start or refresh key locks them again, and writes while locked are ignored.
- R5: The divide code selects a slow-clock ratio. Codes 0 to 6 give 4 shifted left by the code, and code 7 gives 256.
- R6: After each reload, `reset_req` stays low for exactly ratio × reload slow cycles. A reload of 0 acts as 1.
- R7: A refresh (0xAAAA) reloads the count and restarts the prescaler, so refreshes issued faster than the timeout keep `reset_req` low. Newly written configuration takes effect from the next reload.
- R8: Each request is a single high pulse of exactly 2 slow cycles. After it, the count reloads and runs again.
- R9: While `dbg_halt` is high, the prescaler and the count hold. A pulse already begun still lasts its full width.
- R10: `busy` rises in the bus cycle after an accepted command write. It stays high until the slow domain has applied the command, and writes made meanwhile are queued and merged.
- R11: The count and the pulses go on with the bus clock stopped.
- R12: When a refresh meets the final divided tick in the same slow cycle, the refresh wins and no pulse occurs. Every pulse stays exactly 2 cycles whatever the refresh timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock for the register port |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register select: 0 key, 1 divide code, 2 reload |
| reg_wdata | input | 16 | Write data |
| busy | output | 1 | A command has not yet been applied in the slow domain |
| armed | output | 1 | The watchdog has been started |
| slow_clk | input | 1 | Independent slow counting clock |
| slow_rst_n | input | 1 | Active-low asynchronous reset, slow domain |
| dbg_halt | input | 1 | Freeze counting while the processor is halted in debug |
| reset_req | output | 1 | Reset request pulse, slow domain |

## Verification
The two functions that can meet in one slow cycle are a refresh arriving from the handshake and the divided tick that would use up the count. The bench provokes this by sweeping the moment a refresh is written across each step of a short 12-cycle period, right after successive pulses. A monitor judges every pulse that occurs: each must be exactly two slow cycles wide. After the sweep, the bench checks that the next full period is still exact, so a refresh racing an expiry neither truncates a pulse nor shifts the timing. The same width monitor covers a debug halt raised at the rising edge of a pulse.

// File: rtl/iwdg_pkg.sv
`timescale 1ns/1ps
package iwdg_pkg;

    localparam int KEY_W   = 16;
    localparam int CODE_W  = 3;
    localparam int RLD_W   = 12;
    localparam int DIV_W   = 8;

    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;

    localparam logic [1:0] ADDR_KEY = 2'd0;
    localparam logic [1:0] ADDR_DIV = 2'd1;
    localparam logic [1:0] ADDR_RLD = 2'd2;

    localparam logic [CODE_W-1:0] CODE_RST = '0;
    localparam logic [RLD_W-1:0]  RLD_RST  = '1;

    typedef struct packed {
        logic              start;
        logic              refresh;
        logic              load;
        logic [CODE_W-1:0] code;
        logic [RLD_W-1:0]  reload;
    } iwdg_cmd_t;

    typedef enum logic {
        BUS_IDLE,
        BUS_WAIT
    } bus_state_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_HALT,
        ST_FIRE
    } wd_state_e;

    // Last prescaler count before a divided tick: ratio minus one.
    function automatic logic [DIV_W-1:0] div_last(input logic [CODE_W-1:0] code);
        logic [DIV_W-1:0] r;
        unique case (code)
            3'd0:    r = 8'd3;
            3'd1:    r = 8'd7;
            3'd2:    r = 8'd15;
            3'd3:    r = 8'd31;
            3'd4:    r = 8'd63;
            3'd5:    r = 8'd127;
            default: r = 8'd255;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/iwdg_sync.sv
`timescale 1ns/1ps
module iwdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= 1'b0;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[N-1];

endmodule

// File: rtl/iwdg_bus_ctl.sv
`timescale 1ns/1ps
module iwdg_bus_ctl
    import iwdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             ack_s,
    output logic             req_tgl,
    output iwdg_cmd_t        cmd,
    output logic             busy,
    output logic             armed
);
    bus_state_e        bstate_q, bstate_d;
    logic              req_q;
    iwdg_cmd_t         cmd_q;
    logic              pend_start, pend_refresh, pend_cfg;
    logic              unlock_q, armed_q;
    logic [CODE_W-1:0] code_q;
    logic [RLD_W-1:0]  reload_q;

    logic key_hit, hit_start, hit_refresh, hit_unlock;
    logic cfg_div, cfg_rld, any_pend, launch;

    always_comb begin
        key_hit     = wr_en && (wr_addr == ADDR_KEY);
        hit_start   = key_hit && (wr_data == KEY_START);
        hit_refresh = key_hit && (wr_data == KEY_REFRESH);
        hit_unlock  = key_hit && (wr_data == KEY_UNLOCK);
        cfg_div     = wr_en && (wr_addr == ADDR_DIV) && unlock_q;
        cfg_rld     = wr_en && (wr_addr == ADDR_RLD) && unlock_q;
        any_pend    = pend_start || pend_refresh || pend_cfg;
        launch      = (bstate_q == BUS_IDLE) && any_pend;
    end

    // Next state
    always_comb begin
        bstate_d = bstate_q;
        unique case (bstate_q)
            BUS_IDLE: if (launch)         bstate_d = BUS_WAIT;
            BUS_WAIT: if (ack_s == req_q) bstate_d = BUS_IDLE;
            default:                      bstate_d = BUS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bstate_q <= BUS_IDLE;
        else        bstate_q <= bstate_d;
    end

    // Command queue, shadow configuration and launch payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q        <= 1'b0;
            cmd_q        <= '0;
            pend_start   <= 1'b0;
            pend_refresh <= 1'b0;
            pend_cfg     <= 1'b0;
            unlock_q     <= 1'b0;
            armed_q      <= 1'b0;
            code_q       <= CODE_RST;
            reload_q     <= RLD_RST;
        end else begin
            pend_start   <= (pend_start   && !launch) || hit_start;
            pend_refresh <= (pend_refresh && !launch) || hit_refresh;
            pend_cfg     <= (pend_cfg     && !launch) || cfg_div || cfg_rld;
            if (launch) begin
                cmd_q.start   <= pend_start;
                cmd_q.refresh <= pend_refresh;
                cmd_q.load    <= pend_cfg;
                cmd_q.code    <= code_q;
                cmd_q.reload  <= reload_q;
                req_q         <= !req_q;
            end
            if (hit_unlock)                    unlock_q <= 1'b1;
            else if (hit_start || hit_refresh) unlock_q <= 1'b0;
            if (hit_start) armed_q  <= 1'b1;
            if (cfg_div)   code_q   <= wr_data[CODE_W-1:0];
            if (cfg_rld)   reload_q <= wr_data[RLD_W-1:0];
        end
    end

    // Outputs
    always_comb begin
        req_tgl = req_q;
        cmd     = cmd_q;
        busy    = (bstate_q == BUS_WAIT) || any_pend;
        armed   = armed_q;
    end

    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R3
    AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_tgl != ack_s) |-> busy); // R10
    AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bstate_q == BUS_WAIT) |=> $stable(cmd)); // R10

endmodule

// File: rtl/iwdg_core.sv
`timescale 1ns/1ps
module iwdg_core
    import iwdg_pkg::*;
#(
    parameter int PULSE_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_s,
    input  iwdg_cmd_t cmd,
    input  logic      halt_s,
    output logic      ack_tgl,
    output logic      reset_req
);
    localparam int FIRE_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam logic [FIRE_W-1:0] FIRE_LAST = FIRE_W'(PULSE_CYC - 1);

    wd_state_e         state_q, state_d;
    logic              seen_q;
    logic [RLD_W-1:0]  cnt_q, cnt_d;
    logic [DIV_W-1:0]  pre_q, pre_d;
    logic [FIRE_W-1:0] fire_q, fire_d;
    logic [CODE_W-1:0] code_act, new_code;
    logic [RLD_W-1:0]  rld_act, new_rld;

    logic apply, do_start, do_refresh, tick;

    always_comb begin
        apply      = (req_s != seen_q);
        new_code   = (apply && cmd.load) ? cmd.code   : code_act;
        new_rld    = (apply && cmd.load) ? cmd.reload : rld_act;
        do_start   = apply && cmd.start && (state_q == ST_OFF);
        do_refresh = apply && cmd.refresh &&
                     ((state_q == ST_RUN) || (state_q == ST_HALT));
        tick       = (pre_q >= div_last(code_act));
    end

    // Next state and counter updates
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pre_d   = pre_q;
        fire_d  = fire_q;
        unique case (state_q)
            ST_OFF: begin
                if (do_start) begin
                    state_d = ST_RUN;
                    cnt_d   = new_rld;
                    pre_d   = '0;
                end
            end
            ST_RUN: begin
                if (do_refresh) begin
                    cnt_d = new_rld;
                    pre_d = '0;
                end else if (halt_s) begin
                    state_d = ST_HALT;
                end else if (tick) begin
                    pre_d = '0;
                    if (cnt_q <= RLD_W'(1)) begin
                        state_d = ST_FIRE;
                        cnt_d   = '0;
                        fire_d  = '0;
                    end else begin
                        cnt_d = cnt_q - RLD_W'(1);
                    end
                end else begin
                    pre_d = pre_q + DIV_W'(1);
                end
            end
            ST_HALT: begin
                if (do_refresh) begin
                    cnt_d = new_rld;
                    pre_d = '0;
                end
                if (!halt_s) state_d = ST_RUN;
            end
            ST_FIRE: begin
                if (fire_q == FIRE_LAST) begin
                    state_d = ST_RUN;
                    cnt_d   = new_rld;
                    pre_d   = '0;
                end else begin
                    fire_d = fire_q + FIRE_W'(1);
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q   <= 1'b0;
            cnt_q    <= RLD_RST;
            pre_q    <= '0;
            fire_q   <= '0;
            code_act <= CODE_RST;
            rld_act  <= RLD_RST;
        end else begin
            seen_q   <= req_s;
            cnt_q    <= cnt_d;
            pre_q    <= pre_d;
            fire_q   <= fire_d;
            code_act <= new_code;
            rld_act  <= new_rld;
        end
    end

    // Outputs
    always_comb begin
        reset_req = (state_q == ST_FIRE);
        ack_tgl   = seen_q;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_req) |-> ($past(reset_req, 1) && $past(reset_req, 2))); // R8
    AST_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |=> (state_q != ST_OFF)); // R3
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HALT) && !do_refresh) |=> ($stable(cnt_q) && $stable(pre_q))); // R9
    AST_CFG_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rld_act != $past(rld_act)) |-> $past(apply && cmd.load)); // R10

endmodule

// File: rtl/iwdg_top.sv
`timescale 1ns/1ps
module iwdg_top
    import iwdg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [KEY_W-1:0] reg_wdata,
    output logic             busy,
    output logic             armed,
    input  logic             slow_clk,
    input  logic             slow_rst_n,
    input  logic             dbg_halt,
    output logic             reset_req
);
    logic      req_tgl, req_s, ack_tgl, ack_s, halt_s;
    iwdg_cmd_t cmd;

    iwdg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_s));

    iwdg_bus_ctl u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n), .wr_en(reg_wr), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .ack_s(ack_s), .req_tgl(req_tgl), .cmd(cmd),
        .busy(busy), .armed(armed));

    iwdg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(req_tgl), .q(req_s));

    iwdg_sync #(.STAGES(SYNC_STAGES)) u_halt_sync (
        .clk(slow_clk), .rst_n(slow_rst_n), .d(dbg_halt), .q(halt_s));

    iwdg_core #(.PULSE_CYC(PULSE_CYC)) u_core (
        .clk(slow_clk), .rst_n(slow_rst_n), .req_s(req_s), .cmd(cmd),
        .halt_s(halt_s), .ack_tgl(ack_tgl), .reset_req(reset_req));

endmodule

// File: tb/iwdg_top_bench.sv
`timescale 1ns/1ps
module iwdg_top_bench;

    logic        bus_clk = 1'b0, slow_clk = 1'b0, bus_en = 1'b1;
    logic        bus_rst_n = 1'b0, slow_rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        dbg_halt = 1'b0;
    logic        busy, armed, reset_req;

    int n_checks = 0, n_fail = 0;
    int pulse_cnt = 0, hi_run = 0, lo_run = 0, last_lo = 0;

    always #10ns bus_clk = bus_en ? ~bus_clk : 1'b0;
    always #50ns slow_clk = ~slow_clk;

    iwdg_top u_iwdg_top (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(busy), .armed(armed),
        .slow_clk(slow_clk), .slow_rst_n(slow_rst_n), .dbg_halt(dbg_halt),
        .reset_req(reset_req));

    // {divide code, reload, expected low cycles}
    localparam int VEC[8][3] = '{
        '{0, 5, 20}, '{1, 3, 24}, '{2, 0, 16}, '{5, 2, 256},
        '{7, 1, 256}, '{6, 2, 512}, '{3, 6, 192}, '{4, 1, 64}};

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse monitor: every pulse must be exactly two slow cycles (R8, R12)
    always @(negedge slow_clk) begin
        if (!slow_rst_n) begin
            hi_run = 0; lo_run = 0;
        end else if (reset_req) begin
            if (hi_run == 0) begin
                last_lo = lo_run;
                pulse_cnt++;
                lo_run = 0;
            end
            hi_run++;
        end else begin
            if (hi_run != 0) begin
                chk(hi_run == 2, "R8 pulse width", hi_run, 2);
                hi_run = 0;
            end
            lo_run++;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge bus_clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge bus_clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 400 && busy; g++) @(negedge bus_clk);
        chk(!busy, "R10 busy clears", busy, 0);
    endtask

    task automatic slow_wait(input int n);
        repeat (n) @(negedge slow_clk);
    endtask

    task automatic config_refresh(input int code, input int rld);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wr(2'd2, 16'(rld));
        wr(2'd0, 16'hAAAA);
        wait_idle();
    endtask

    task automatic measure(input string tag, input int exp);
        int p0;
        p0 = pulse_cnt;
        for (int g = 0; g < 3000 && pulse_cnt < p0 + 2; g++) @(negedge slow_clk);
        chk(pulse_cnt >= p0 + 2, {tag, " pulses seen"}, pulse_cnt - p0, 2);
        chk(last_lo == exp, {tag, " low period"}, last_lo, exp);
    endtask

    initial begin
        #3_000_000ns;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int p;
        repeat (4) @(negedge slow_clk);
        bus_rst_n = 1'b1; slow_rst_n = 1'b1;
        repeat (3) @(negedge bus_clk);
        // R1 reset state
        chk(!reset_req && !busy && !armed, "R1 reset outputs",
            {reset_req, busy, armed}, 0);

        // R2 non-key values and configuration do not start
        wr(2'd0, 16'hCCCD);
        wr(2'd0, 16'h0000);
        @(negedge bus_clk);
        chk(!busy, "R2 bad key no command", busy, 0);
        chk(!armed, "R2 bad key not armed", armed, 0);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd5);
        wait_idle();
        p = pulse_cnt;
        slow_wait(200);
        chk(pulse_cnt == p, "R2 no pulse before start", pulse_cnt - p, 0);

        // R2/R10 start
        @(negedge bus_clk);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'hCCCC;
        @(negedge bus_clk);
        reg_wr = 1'b0;
        chk(armed, "R2 armed after start", armed, 1);
        chk(busy, "R10 busy after command", busy, 1);
        wait_idle();
        measure("R6 first period", 20);

        // R5/R6 table walk
        for (int i = 0; i < 8; i++) begin
            config_refresh(VEC[i][0], VEC[i][1]);
            measure($sformatf("R5 R6 vec%0d", i), VEC[i][2]);
        end

        // R4 locked writes ignored
        config_refresh(0, 40);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'hAAAA);
        wait_idle();
        measure("R4 locked reload", 160);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        wr(2'd2, 16'd2);
        wr(2'd0, 16'hAAAA);
        wait_idle();
        measure("R4 relocked by refresh", 160);

        // R7 refresh keeps the request low
        wr(2'd0, 16'hAAAA);
        wait_idle();
        p = pulse_cnt;
        for (int k = 0; k < 8; k++) begin
            slow_wait(60);
            wr(2'd0, 16'hAAAA);
        end
        chk(pulse_cnt == p, "R7 refresh holds off", pulse_cnt - p, 0);
        p = pulse_cnt;
        for (int k = 0; k < 5; k++) begin
            slow_wait(60);
            wr(2'd0, 16'hAAAB);
        end
        chk(pulse_cnt > p, "R2 bad refresh key ignored", pulse_cnt - p, 1);

        // R3 no write disables
        config_refresh(0, 2);
        measure("R4 unlocked reload", 8);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hFFFF);
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h3333);
        chk(armed, "R3 armed sticky", armed, 1);
        p = pulse_cnt;
        slow_wait(100);
        chk(pulse_cnt >= p + 8, "R3 still counting", pulse_cnt - p, 10);

        // R9 debug freeze
        config_refresh(0, 3);
        @(posedge reset_req);
        dbg_halt = 1'b1;
        slow_wait(6);
        p = pulse_cnt;
        slow_wait(600);
        chk(pulse_cnt == p, "R9 halted no pulse", pulse_cnt - p, 0);
        dbg_halt = 1'b0;
        slow_wait(30);
        chk(pulse_cnt > p, "R9 resumes", pulse_cnt - p, 1);

        // R12 refresh swept across the expiry tick
        for (int k = 0; k < 14; k++) begin
            @(posedge reset_req);
            slow_wait(k);
            wr(2'd0, 16'hAAAA);
        end
        wait_idle();
        measure("R12 period after sweep", 12);

        // R11 bus clock stopped
        config_refresh(0, 2);
        @(negedge bus_clk);
        bus_en = 1'b0;
        p = pulse_cnt;
        slow_wait(50);
        chk(pulse_cnt >= p + 4, "R11 pulses without bus clock", pulse_cnt - p, 5);
        chk(last_lo == 8, "R11 period without bus clock", last_lo, 8);
        bus_en = 1'b1;
        repeat (4) @(negedge bus_clk);

        // R1/R3 only reset disarms
        bus_rst_n = 1'b0; slow_rst_n = 1'b0;
        slow_wait(3);
        bus_rst_n = 1'b1; slow_rst_n = 1'b1;
        @(negedge bus_clk);
        chk(!armed && !busy, "R1 R3 reset disarms", {armed, busy}, 0);
        p = pulse_cnt;
        slow_wait(200);
        chk(pulse_cnt == p && !reset_req, "R1 quiet after reset", pulse_cnt - p, 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule